// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Through Cache

This block is a small data cache between a processor-side word port and a lower-level memory. Each set holds two ways. A lookup compares the two stored tags of the indexed set at the same time, each tag qualified by its valid bit. The two match results are ORed to form the hit. They then steer a multiplexer that picks the block of the matching way, so read data is ready only once the hit is known. A read miss fetches the whole block from memory and places it in the least-recently-used way of its set.

Every store goes to memory. A store that hits also updates the cached word. Each store is posted into a four-entry first-in first-out buffer, and the buffer drains over a separate word-write port. A store that misses does not allocate a line. A read never causes a writeback. If a read misses on a block that still has a posted store in the buffer, the read is held until that store has reached memory.

On the processor side, a request is held until `cpu_done` pulses for one cycle. For a read, `cpu_rdata` is valid in that same cycle.

Top module: `wt_cache`

## Requirements
- R1: A byte address splits into tag [31:9], set index [8:5] and block offset [4:0], so a block goes to set (block address mod 16). Only bits [4:2] pick the word inside the block, and offset bits never take part in the tag compare.
- R2: A read that hits returns the stored word with a single `cpu_done` pulse and issues no memory read.
- R3: A read miss raises `mem_rd_req` with the block-aligned address, held steady until `mem_rd_valid`. Word i of `mem_rd_data` sits in bits [32i+31:32i]. The fetched block is installed and the requested word is returned, and later reads of that block hit.
- R4: Each set keeps one LRU bit. Every hit and every fill point it at the other way, and a miss fills the way it names.
- R5: Every store enters the write buffer, and the buffer presents stores on the write port in issue order. One entry is removed for each cycle in which `mem_wr_ack` is high while `mem_wr_req` is high.
- R6: A store that hits updates the cached word, so a later read returns the new data without a memory read.
- R7: A store that misses does not allocate, so a later read of that address misses and fetches from memory.
- R8: The buffer holds 4 stores. A fifth store is not completed (no `cpu_done`) until an entry drains.
- R9: A read miss whose block matches a pending buffer entry issues no memory read until no pending entry matches.
- R10: Reset clears all valid and LRU bits and empties the write buffer, so after reset `mem_wr_req` is low and the first read misses.
- R11: At most one way of a set matches a given tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address (word aligned) |
| cpu_wdata | input | 32 | Store data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Load data, valid with `cpu_done` |
| mem_rd_req | output | 1 | Block fetch request |
| mem_rd_addr | output | 32 | Block-aligned fetch address |
| mem_rd_valid | input | 1 | Fetched block present |
| mem_rd_data | input | 256 | Fetched block, word 0 in low bits |
| mem_wr_req | output | 1 | Write buffer not empty |
| mem_wr_addr | output | 32 | Address of oldest posted store |
| mem_wr_data | output | 32 | Data of oldest posted store |
| mem_wr_ack | input | 1 | Oldest store accepted by memory |

## Verification
A wrong LRU bit does not show on the access that corrupts it. It shows one miss later, when a third block in the same set evicts the line just used, and the next access to that line costs an extra `mem_rd_req`. A stale valid bit or tag shows at once, either as a missing fetch with wrong data or as a fetch on an access that should hit. A buffer pointer or match fault shows on the write port as reordered stores, or as a read that fetches memory before its pending store has drained and so returns old data.

// File: rtl/wt_cache_pkg.sv
package wt_cache_pkg;
  localparam int WAYS = 2;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_REFILL = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/wt_cache_way.sv
module wt_cache_way #(
  parameter int SETS   = 16,
  parameter int TAG_W  = 23,
  parameter int BLK_W  = 256,
  parameter int WORD_W = 32,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WSEL_W = $clog2(BLK_W / WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  idx,
  input  logic [TAG_W-1:0]  tag,
  output logic              hit,
  output logic [BLK_W-1:0]  blk,
  input  logic              fill_en,
  input  logic [BLK_W-1:0]  fill_blk,
  input  logic              wr_en,
  input  logic [WSEL_W-1:0] wr_sel,
  input  logic [WORD_W-1:0] wr_word
);
  logic [BLK_W-1:0] data_q [SETS];
  logic [TAG_W-1:0] tag_q  [SETS];
  logic [SETS-1:0]  valid_q;

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (fill_en) begin
      data_q[idx] <= fill_blk;
      tag_q[idx]  <= tag;
    end else if (wr_en) begin
      data_q[idx][wr_sel*WORD_W +: WORD_W] <= wr_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          valid_q <= '0;
    else if (fill_en) valid_q[idx] <= 1'b1;
  end

  assign hit = valid_q[idx] && (tag_q[idx] == tag);
  assign blk = data_q[idx];

  // a word update only lands on a line that already holds the tag
  p_wr_only_on_hit_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> hit);
  p_fill_only_on_miss_r3: assert property (@(posedge clk) disable iff (rst)
    fill_en |-> !hit);
endmodule

// File: rtl/wt_cache_wbuf.sv
module wt_cache_wbuf #(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int OFF_W = 5,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic          full,
  output logic          empty,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  input  logic [AW-1:0] probe_addr,
  output logic          probe_hit
);
  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [DEPTH-1:0] live_q;
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;

  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign empty     = (cnt_q == '0);
  assign head_addr = addr_q[rp_q];
  assign head_data = data_q[rp_q];

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wp_q] <= push_addr;
      data_q[wp_q] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      live_q <= '0;
    end else begin
      if (push) begin
        wp_q         <= wp_q + 1'b1;
        live_q[wp_q] <= 1'b1;
      end
      if (pop) begin
        rp_q         <= rp_q + 1'b1;
        live_q[rp_q] <= 1'b0;
      end
      cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
    end
  end

  // block-level match against every pending store
  always_comb begin
    probe_hit = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (live_q[i] && addr_q[i][AW-1:OFF_W] == probe_addr[AW-1:OFF_W])
        probe_hit = 1'b1;
    end
  end

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    !(push && full));
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
  p_live_count_r5: assert property (@(posedge clk) disable iff (rst)
    $countones(live_q) == int'(cnt_q));
  p_reset_empty_r10: assert property (@(posedge clk)
    rst |=> empty);
endmodule

// File: rtl/wt_cache.sv
module wt_cache
  import wt_cache_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int WORD_W      = 32,
  parameter int BLOCK_BYTES = 32,
  parameter int SETS        = 16,
  parameter int WB_DEPTH    = 4,
  localparam int BLK_W      = BLOCK_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic              cpu_done,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [BLK_W-1:0]  mem_rd_data,
  output logic              mem_wr_req,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [WORD_W-1:0] mem_wr_data,
  input  logic              mem_wr_ack
);
  localparam int OFF_W    = $clog2(BLOCK_BYTES);
  localparam int IDX_W    = $clog2(SETS);
  localparam int TAG_W    = ADDR_W - OFF_W - IDX_W;
  localparam int BYTE_OFF = $clog2(WORD_W / 8);
  localparam int WSEL_W   = $clog2(BLK_W / WORD_W);

  ctl_state_e        state_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q;
  logic [SETS-1:0]   lru_q;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [WSEL_W-1:0] wsel;
  logic [WAYS-1:0]   way_hit, fill_en, wr_en;
  logic [BLK_W-1:0]  way_blk [WAYS];
  logic [BLK_W-1:0]  sel_blk;
  logic              any_hit, hit_way, victim;
  logic              in_lookup, wb_push, wb_full, wb_empty, wb_conflict;
  logic              wr_hit_go, fill_go;

  assign idx  = addr_q[OFF_W +: IDX_W];
  assign tag  = addr_q[ADDR_W-1 -: TAG_W];
  assign wsel = addr_q[BYTE_OFF +: WSEL_W];

  assign in_lookup = (state_q == ST_LOOKUP);
  assign wb_push   = in_lookup && we_q && !wb_full;
  assign wr_hit_go = wb_push && any_hit;
  assign fill_go   = (state_q == ST_REFILL) && mem_rd_valid;
  assign victim    = lru_q[idx];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign fill_en[w] = fill_go && (victim == 1'(w));
    assign wr_en[w]   = wr_hit_go && way_hit[w];

    wt_cache_way #(
      .SETS(SETS), .TAG_W(TAG_W), .BLK_W(BLK_W), .WORD_W(WORD_W)
    ) way_i (
      .clk(clk), .rst(rst), .idx(idx), .tag(tag),
      .hit(way_hit[w]), .blk(way_blk[w]),
      .fill_en(fill_en[w]), .fill_blk(mem_rd_data),
      .wr_en(wr_en[w]), .wr_sel(wsel), .wr_word(wdata_q)
    );
  end

  // hit is resolved first, then steers the block mux
  assign any_hit = |way_hit;
  assign hit_way = way_hit[1];
  assign sel_blk = hit_way ? way_blk[1] : way_blk[0];

  wt_cache_wbuf #(
    .DEPTH(WB_DEPTH), .AW(ADDR_W), .DW(WORD_W), .OFF_W(OFF_W)
  ) wbuf_i (
    .clk(clk), .rst(rst),
    .push(wb_push), .push_addr(addr_q), .push_data(wdata_q),
    .pop(mem_wr_ack), .full(wb_full), .empty(wb_empty),
    .head_addr(mem_wr_addr), .head_data(mem_wr_data),
    .probe_addr(addr_q), .probe_hit(wb_conflict)
  );

  assign mem_wr_req  = !wb_empty;
  assign mem_rd_req  = (state_q == ST_REFILL);
  assign mem_rd_addr = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      we_q      <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      lru_q     <= '0;
      cpu_done  <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      cpu_done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (cpu_req) begin
            we_q    <= cpu_we;
            addr_q  <= cpu_addr;
            wdata_q <= cpu_wdata;
            state_q <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          if (we_q) begin
            if (!wb_full) begin
              if (any_hit) lru_q[idx] <= ~hit_way;
              cpu_done <= 1'b1;
              state_q  <= ST_IDLE;
            end
          end else if (any_hit) begin
            lru_q[idx] <= ~hit_way;
            cpu_rdata  <= sel_blk[wsel*WORD_W +: WORD_W];
            cpu_done   <= 1'b1;
            state_q    <= ST_IDLE;
          end else if (!wb_conflict) begin
            state_q <= ST_REFILL;
          end
        end
        ST_REFILL: begin
          if (mem_rd_valid) begin
            lru_q[idx] <= ~victim;
            cpu_rdata  <= mem_rd_data[wsel*WORD_W +: WORD_W];
            cpu_done   <= 1'b1;
            state_q    <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_hit_onehot_r11: assert property (@(posedge clk) disable iff (rst)
    in_lookup |-> $onehot0(way_hit));
  p_fetch_not_stale_r9: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> !wb_conflict);
  p_fetch_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    cpu_done |=> !cpu_done);
  p_fill_flips_lru_r4: assert property (@(posedge clk) disable iff (rst)
    fill_go |=> (lru_q[$past(idx)] != $past(victim)));
endmodule

// File: tb/wt_cache_tb_top.sv
module wt_cache_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cpu_req = 1'b0;
  logic         cpu_we = 1'b0;
  logic [31:0]  cpu_addr = '0;
  logic [31:0]  cpu_wdata = '0;
  logic         cpu_done;
  logic [31:0]  cpu_rdata;
  logic         mem_rd_req;
  logic [31:0]  mem_rd_addr;
  logic         mem_rd_valid = 1'b0;
  logic [255:0] mem_rd_data = '0;
  logic         mem_wr_req;
  logic [31:0]  mem_wr_addr;
  logic [31:0]  mem_wr_data;
  logic         mem_wr_ack = 1'b0;

  logic         wr_ack_en = 1'b0;
  int           tests = 0;
  int           fails = 0;
  int           cyc = 0;
  int           rd_count = 0;
  int           rd_dly = 0;
  logic [31:0]  last_rd_addr = '0;
  logic [31:0]  model [1024];
  logic         model_init = 1'b0;
  logic [31:0]  wlog_addr [32];
  logic [31:0]  wlog_data [32];
  int           wlog_cnt = 0;

  always #10 clk = ~clk;

  wt_cache dut_i (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return 32'hC0DE_0000 ^ a;
  endfunction

  // memory model: block reads after two cycles, word writes acknowledged
  always @(negedge clk) begin
    if (!model_init) begin
      for (int i = 0; i < 1024; i++) model[i] = pat(32'(i * 4));
      model_init = 1'b1;
    end
    if (mem_rd_valid) begin
      mem_rd_valid = 1'b0;
    end else if (mem_rd_req) begin
      if (rd_dly == 2) begin
        for (int k = 0; k < 8; k++)
          mem_rd_data[k*32 +: 32] = model[mem_rd_addr[11:2] + 10'(k)];
        last_rd_addr = mem_rd_addr;
        mem_rd_valid = 1'b1;
        rd_count++;
        rd_dly = 0;
      end else begin
        rd_dly++;
      end
    end
    if (mem_wr_ack) begin
      mem_wr_ack = 1'b0;
    end else if (mem_wr_req && wr_ack_en) begin
      model[mem_wr_addr[11:2]] = mem_wr_data;
      if (wlog_cnt < 32) begin
        wlog_addr[wlog_cnt] = mem_wr_addr;
        wlog_data[wlog_cnt] = mem_wr_data;
      end
      wlog_cnt++;
      mem_wr_ack = 1'b1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cpu_read(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
    do @(negedge clk); while (!cpu_done);
    d = cpu_rdata;
    cpu_req = 1'b0;
  endtask

  task automatic cpu_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    do @(negedge clk); while (!cpu_done);
    cpu_req = 1'b0;
  endtask

  task automatic drain();
    wr_ack_en = 1'b1;
    while (mem_wr_req) @(negedge clk);
    repeat (2) @(negedge clk);
    wr_ack_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 wr_req after reset", 32'(mem_wr_req), 32'd0);
    chk("R10 rd_req after reset", 32'(mem_rd_req), 32'd0);
    chk("R10 done after reset", 32'(cpu_done), 32'd0);
  endtask

  task automatic t_miss_and_index();
    logic [31:0] d;
    int base = rd_count;
    cpu_read(32'h104, d);
    chk("R3 miss data", d, pat(32'h104));
    chk("R3 fetch count", 32'(rd_count - base), 32'd1);
    chk("R3 aligned fetch addr", last_rd_addr, 32'h100);
    chk("R10 first read misses", 32'(rd_count - base), 32'd1);
    cpu_read(32'h11C, d);
    chk("R2 hit other word", d, pat(32'h11C));
    chk("R2 hit no fetch", 32'(rd_count - base), 32'd1);
    cpu_read(32'h300, d);
    chk("R1 same set new tag", d, pat(32'h300));
    chk("R1 same set fetch", 32'(rd_count - base), 32'd2);
    cpu_read(32'h108, d);
    cpu_read(32'h304, d);
    chk("R1 two ways resident", 32'(rd_count - base), 32'd2);
    cpu_read(32'h120, d);
    chk("R1 next set misses", 32'(rd_count - base), 32'd3);
  endtask

  task automatic t_lru();
    logic [31:0] d;
    int base = rd_count;
    cpu_read(32'h060, d);
    cpu_read(32'h260, d);
    cpu_read(32'h064, d);
    chk("R4 two fills", 32'(rd_count - base), 32'd2);
    cpu_read(32'h460, d);
    chk("R4 third block data", d, pat(32'h460));
    cpu_read(32'h068, d);
    chk("R4 recently used kept", 32'(rd_count - base), 32'd3);
    cpu_read(32'h264, d);
    chk("R4 lru evicted", 32'(rd_count - base), 32'd4);
    chk("R4 refetched data", d, pat(32'h264));
  endtask

  task automatic t_write_hit();
    logic [31:0] d;
    int base = rd_count;
    int lbase = wlog_cnt;
    cpu_write(32'h104, 32'hDEAD_0104);
    cpu_read(32'h104, d);
    chk("R6 updated word", d, 32'hDEAD_0104);
    chk("R6 no fetch", 32'(rd_count - base), 32'd0);
    drain();
    chk("R5 write through count", 32'(wlog_cnt - lbase), 32'd1);
    chk("R5 write through addr", wlog_addr[lbase], 32'h104);
    chk("R5 write through data", wlog_data[lbase], 32'hDEAD_0104);
  endtask

  task automatic t_write_miss();
    logic [31:0] d;
    int base;
    cpu_write(32'h800, 32'h5555_0800);
    drain();
    base = rd_count;
    cpu_read(32'h800, d);
    chk("R7 no allocate fetch", 32'(rd_count - base), 32'd1);
    chk("R7 data from memory", d, 32'h5555_0800);
  endtask

  task automatic t_order_and_full();
    int lbase = wlog_cnt;
    logic seen = 1'b0;
    for (int i = 0; i < 4; i++) cpu_write(32'h040 + 32'(i * 4), 32'hA000_0000 + 32'(i));
    chk("R5 pending write visible", 32'(mem_wr_req), 32'd1);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 32'h050; cpu_wdata = 32'hA000_0004;
    repeat (10) begin
      @(negedge clk);
      if (cpu_done) seen = 1'b1;
    end
    chk("R8 fifth store stalls", 32'(seen), 32'd0);
    wr_ack_en = 1'b1;
    while (!cpu_done) @(negedge clk);
    cpu_req = 1'b0;
    drain();
    chk("R8 all stores drained", 32'(wlog_cnt - lbase), 32'd5);
    for (int i = 0; i < 5; i++) begin
      chk("R5 order addr", wlog_addr[lbase + i], 32'h040 + 32'(i * 4));
      chk("R5 order data", wlog_data[lbase + i], 32'hA000_0000 + 32'(i));
    end
  endtask

  task automatic t_raw();
    logic seen = 1'b0;
    int base;
    cpu_write(32'hA04, 32'h7777_0A04);
    base = rd_count;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 32'hA04;
    repeat (10) begin
      @(negedge clk);
      if (cpu_done) seen = 1'b1;
    end
    chk("R9 read held", 32'(seen), 32'd0);
    chk("R9 no fetch while pending", 32'(rd_count - base), 32'd0);
    wr_ack_en = 1'b1;
    while (!cpu_done) @(negedge clk);
    chk("R9 data after drain", cpu_rdata, 32'h7777_0A04);
    cpu_req = 1'b0;
    wr_ack_en = 1'b0;
    chk("R9 one fetch", 32'(rd_count - base), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_miss_and_index();
    t_lru();
    t_write_hit();
    t_write_miss();
    t_order_and_full();
    t_raw();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        tests++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end
endmodule